// File: doc/BRIEF.md
# Configuration Capability Chain Walker

This block walks the capability linked lists of a PCI or PCI Express configuration space and streams one record per capability it finds. It reaches the configuration space through a byte-wide, single-port read port: when `rd_en` is high in a cycle, the byte at `rd_addr` must appear on `rd_data` in the next cycle. A one-cycle `start` pulse begins a walk. The block first tests the capability-list bit in the status byte. It then follows the legacy list that lives in the first 256 bytes. When `space_4k` is high at the start, it goes on to follow the extended list that begins at byte 0x100. Each record carries a list flag, the capability ID, its byte offset and, for extended entries, the version nibble. At the end, `done` rises and stays high. The flags `is_pcie`, `has_aer`, `has_rebar` and `err` then describe the device.

Records leave through a valid/ready handshake, and the walk waits while `rec_ready` is low. Hop counters bound both lists, so a chain that loops back on itself ends with an error. A chain that points outside its own region also ends with an error.

The state machine has these states. S_IDLE waits for start. S_STAT_RQ and S_STAT_CK read the status byte. S_HEAD_RQ and S_HEAD_CK read the head pointer. S_L_EVAL judges a legacy pointer. S_L_ID_RQ, S_L_ID_CK and S_L_NX_CK read the entry's ID byte and next byte. S_L_OUT offers a legacy record. S_E_B0, S_E_B1, S_E_B2, S_E_B3 and S_E_LAST read the four header bytes. S_E_CHK tests for an empty list. S_E_OUT offers an extended record. S_E_EVAL judges an extended pointer. S_DONE holds the result.

The transitions are as follows:
- S_IDLE or S_DONE go to S_STAT_RQ on start.
- S_STAT_CK goes to S_DONE when the list bit is clear, and otherwise to S_HEAD_RQ.
- S_HEAD_CK goes to S_L_EVAL.
- S_L_EVAL goes to S_L_ID_RQ when the pointer is good. On a zero pointer it goes to S_E_B0 if space_4k was set, and otherwise to S_DONE. On a bad pointer or an exhausted hop count it goes to S_DONE with an error.
- S_L_ID_RQ, S_L_ID_CK and S_L_NX_CK advance in sequence to S_L_OUT.
- S_L_OUT goes to S_L_EVAL on handshake.
- S_E_B0 through S_E_LAST advance in sequence to S_E_CHK.
- S_E_CHK goes to S_DONE on an all-zero first header, and otherwise to S_E_OUT.
- S_E_OUT goes to S_E_EVAL on handshake.
- S_E_EVAL goes to S_E_B0 when the next pointer is good. On a zero pointer it goes to S_DONE. On a bad pointer or an exhausted hop count it goes to S_DONE with an error.

Top module: `cfg_cap_walker`

## Requirements
- R1: The first read is of byte 0x06. If bit 4 of that byte (mask 0x10) is 0, the block reaches done with no records, `err` low and `is_pcie` low.
- R2: The legacy head pointer is the byte at 0x34, and its two low bits are forced to 0. Each legacy entry at offset P gives its ID from byte P and its next pointer from byte P+1, and that next pointer also has its two low bits cleared. Each entry yields a record with `rec_ext`=0, `rec_id`={8'h00, ID}, `rec_offset`=P and `rec_ver`=0, emitted in chain order.
- R3: A legacy next pointer of zero ends the legacy walk. If `space_4k` was 0 at the start, the block then reaches done without reporting any extended record.
- R4: `is_pcie` is 1 at done exactly when some legacy record had ID 0x10.
- R5: With `space_4k`=1 at the start, the extended walk begins at 0x100. For a header of bytes b0..b3, the record carries `rec_ext`=1, `rec_id`={b1,b0}, `rec_ver`=b2[3:0], and `rec_offset` equal to the header's own offset. The next offset is {b3, b2[7:4]}.
- R6: The extended walk ends at a next offset of zero, and the entry holding that zero pointer is still reported.
- R7: If all four header bytes at 0x100 are zero, the extended list is empty and yields no record.
- R8: `has_aer` is 1 at done when an extended record had ID 0x0001. `has_rebar` is 1 at done when an extended record had ID 0x0015.
- R9: At most 48 legacy and 960 extended entries are reported. A further nonzero pointer sets `err` and ends the walk with no additional record.
- R10: A nonzero legacy pointer below 0x40, or a nonzero extended pointer below 0x100, sets `err` and ends the walk with no record for that pointer.
- R11: While `rec_valid` is high and `rec_ready` is low, the record fields stay stable and no read is issued.
- R12: After reset, `done`, `busy`, `rec_valid` and `err` are 0. A new start clears all result flags from the previous walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a walk |
| space_4k | input | 1 | 1: 4096-byte space, 0: 256-byte space (sampled at start) |
| rd_en | output | 1 | Read strobe to configuration space |
| rd_addr | output | 12 | Byte address of the read |
| rd_data | input | 8 | Read byte, valid the cycle after rd_en |
| rec_valid | output | 1 | Record offered |
| rec_ready | input | 1 | Record accepted when high with rec_valid |
| rec_ext | output | 1 | 1: extended list record, 0: legacy |
| rec_id | output | 16 | Capability ID |
| rec_offset | output | 12 | Byte offset of the capability header |
| rec_ver | output | 4 | Capability version (0 for legacy) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, held until next start |
| is_pcie | output | 1 | Legacy ID 0x10 seen |
| has_aer | output | 1 | Extended ID 0x0001 seen |
| has_rebar | output | 1 | Extended ID 0x0015 seen |
| err | output | 1 | Walk ended by hop limit or bad pointer |

## Verification
The bench places pointers whose low two bits are set. A walker that skipped the masking would read the wrong entry and report shifted IDs and offsets. Extended headers carry distinct nibbles on each side of byte 2, so a mistake in the nibble packing lands the walk on a wrong offset. The final extended entry has a zero next pointer, and a walker that dropped it would report one record too few. Self-looping chains on both lists check that exactly 48 and 960 records come out before `err`. Out-of-region pointers must end the walk without a spurious record. A held-low ready checks that the record neither changes nor lets reads run ahead.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
    localparam int CFG_AW = 12;

    localparam logic [11:0] ADR_STATUS  = 12'h006;
    localparam logic [11:0] ADR_HEAD    = 12'h034;
    localparam logic [11:0] LEG_FLOOR   = 12'h040;
    localparam logic [11:0] EXT_BASE    = 12'h100;
    localparam int          STAT_LISTBIT = 4;

    localparam logic [7:0]  ID_EXPRESS  = 8'h10;
    localparam logic [15:0] XID_ERRRPT  = 16'h0001;
    localparam logic [15:0] XID_RSZBAR  = 16'h0015;

    typedef enum logic [4:0] {
        S_IDLE, S_STAT_RQ, S_STAT_CK, S_HEAD_RQ, S_HEAD_CK,
        S_L_EVAL, S_L_ID_RQ, S_L_ID_CK, S_L_NX_CK, S_L_OUT,
        S_E_B0, S_E_B1, S_E_B2, S_E_B3, S_E_LAST, S_E_CHK,
        S_E_OUT, S_E_EVAL, S_DONE
    } walk_st_e;

    typedef struct packed {
        logic [15:0] id;
        logic [3:0]  ver;
        logic [11:0] nxt;
        logic        blank;
    } xhdr_t;
endpackage

// File: rtl/cfgw_ext_hdr.sv
module cfgw_ext_hdr
    import cfgw_pkg::*;
(
    input  logic [31:0] hdr,
    output xhdr_t       fields
);
    always_comb begin
        fields.id    = {hdr[15:8], hdr[7:0]};
        fields.ver   = hdr[19:16];
        fields.nxt   = {hdr[31:24], hdr[23:20]};
        fields.blank = (hdr == 32'h0);
    end
endmodule

// File: rtl/cfgw_hop_ctr.sv
module cfgw_hop_ctr #(
    parameter int MAX_HOPS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_max
);
    localparam int CW = $clog2(MAX_HOPS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_HOPS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign at_max = (cnt == LIMIT);
endmodule

// File: rtl/cfg_cap_walker.sv
module cfg_cap_walker
    import cfgw_pkg::*;
#(
    parameter int LEG_MAX_HOPS = 48,
    parameter int EXT_MAX_HOPS = 960
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        space_4k,
    output logic        rd_en,
    output logic [11:0] rd_addr,
    input  logic [7:0]  rd_data,
    output logic        rec_valid,
    input  logic        rec_ready,
    output logic        rec_ext,
    output logic [15:0] rec_id,
    output logic [11:0] rec_offset,
    output logic [3:0]  rec_ver,
    output logic        busy,
    output logic        done,
    output logic        is_pcie,
    output logic        has_aer,
    output logic        has_rebar,
    output logic        err
);
    walk_st_e st, st_nx;

    logic [11:0] cur;
    logic [11:0] lnxt;
    logic [7:0]  lid;
    logic [31:0] hdr;
    logic        sz4k_q;
    xhdr_t       xf;

    logic leg_full, ext_full;
    logic take_go;
    logic leg_step, ext_enter, ext_step;
    logic leg_bad, ext_bad;

    cfgw_ext_hdr u_dec (.hdr(hdr), .fields(xf));

    cfgw_hop_ctr #(.MAX_HOPS(LEG_MAX_HOPS)) u_leg_hops (
        .clk(clk), .rst_n(rst_n), .clr(take_go), .inc(leg_step), .at_max(leg_full));

    cfgw_hop_ctr #(.MAX_HOPS(EXT_MAX_HOPS)) u_ext_hops (
        .clk(clk), .rst_n(rst_n), .clr(take_go), .inc(ext_enter | ext_step), .at_max(ext_full));

    assign take_go   = start && (st == S_IDLE || st == S_DONE);
    assign leg_bad   = (lnxt < LEG_FLOOR) || leg_full;
    assign ext_bad   = (xf.nxt < EXT_BASE) || ext_full;
    assign leg_step  = (st == S_L_EVAL) && (lnxt != '0) && !leg_bad;
    assign ext_enter = (st == S_L_EVAL) && (lnxt == '0) && sz4k_q;
    assign ext_step  = (st == S_E_EVAL) && (xf.nxt != '0) && !ext_bad;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (start) st_nx = S_STAT_RQ;
            S_STAT_RQ: st_nx = S_STAT_CK;
            S_STAT_CK: st_nx = rd_data[STAT_LISTBIT] ? S_HEAD_RQ : S_DONE;
            S_HEAD_RQ: st_nx = S_HEAD_CK;
            S_HEAD_CK: st_nx = S_L_EVAL;
            S_L_EVAL: begin
                if (lnxt == '0)   st_nx = sz4k_q ? S_E_B0 : S_DONE;
                else if (leg_bad) st_nx = S_DONE;
                else              st_nx = S_L_ID_RQ;
            end
            S_L_ID_RQ: st_nx = S_L_ID_CK;
            S_L_ID_CK: st_nx = S_L_NX_CK;
            S_L_NX_CK: st_nx = S_L_OUT;
            S_L_OUT:   if (rec_ready) st_nx = S_L_EVAL;
            S_E_B0:    st_nx = S_E_B1;
            S_E_B1:    st_nx = S_E_B2;
            S_E_B2:    st_nx = S_E_B3;
            S_E_B3:    st_nx = S_E_LAST;
            S_E_LAST:  st_nx = S_E_CHK;
            S_E_CHK:   st_nx = (cur == EXT_BASE && xf.blank) ? S_DONE : S_E_OUT;
            S_E_OUT:   if (rec_ready) st_nx = S_E_EVAL;
            S_E_EVAL: begin
                if (xf.nxt == '0)  st_nx = S_DONE;
                else if (ext_bad)  st_nx = S_DONE;
                else               st_nx = S_E_B0;
            end
            S_DONE:    if (start) st_nx = S_STAT_RQ;
            default:   st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur       <= '0;
            lnxt      <= '0;
            lid       <= '0;
            hdr       <= '0;
            sz4k_q    <= 1'b0;
            is_pcie   <= 1'b0;
            has_aer   <= 1'b0;
            has_rebar <= 1'b0;
            err       <= 1'b0;
        end else begin
            if (take_go) begin
                sz4k_q    <= space_4k;
                is_pcie   <= 1'b0;
                has_aer   <= 1'b0;
                has_rebar <= 1'b0;
                err       <= 1'b0;
            end
            case (st)
                S_HEAD_CK: lnxt <= {4'h0, rd_data[7:2], 2'b00};
                S_L_EVAL: begin
                    if (leg_step)  cur <= lnxt;
                    if (ext_enter) cur <= EXT_BASE;
                    if (lnxt != '0 && leg_bad) err <= 1'b1;
                end
                S_L_ID_CK: lid  <= rd_data;
                S_L_NX_CK: lnxt <= {4'h0, rd_data[7:2], 2'b00};
                S_L_OUT:   if (rec_ready && lid == ID_EXPRESS) is_pcie <= 1'b1;
                S_E_B1:    hdr[7:0]   <= rd_data;
                S_E_B2:    hdr[15:8]  <= rd_data;
                S_E_B3:    hdr[23:16] <= rd_data;
                S_E_LAST:  hdr[31:24] <= rd_data;
                S_E_OUT: begin
                    if (rec_ready && xf.id == XID_ERRRPT) has_aer   <= 1'b1;
                    if (rec_ready && xf.id == XID_RSZBAR) has_rebar <= 1'b1;
                end
                S_E_EVAL: begin
                    if (ext_step) cur <= xf.nxt;
                    if (xf.nxt != '0 && ext_bad) err <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_en      = 1'b0;
        rd_addr    = '0;
        rec_valid  = 1'b0;
        rec_ext    = 1'b0;
        rec_id     = {8'h00, lid};
        rec_ver    = 4'h0;
        rec_offset = cur;
        busy       = !(st == S_IDLE || st == S_DONE);
        done       = (st == S_DONE);
        unique case (st)
            S_STAT_RQ: begin rd_en = 1'b1; rd_addr = ADR_STATUS; end
            S_HEAD_RQ: begin rd_en = 1'b1; rd_addr = ADR_HEAD;   end
            S_L_ID_RQ: begin rd_en = 1'b1; rd_addr = cur;         end
            S_L_ID_CK: begin rd_en = 1'b1; rd_addr = cur + 12'd1; end
            S_E_B0:    begin rd_en = 1'b1; rd_addr = cur;         end
            S_E_B1:    begin rd_en = 1'b1; rd_addr = cur + 12'd1; end
            S_E_B2:    begin rd_en = 1'b1; rd_addr = cur + 12'd2; end
            S_E_B3:    begin rd_en = 1'b1; rd_addr = cur + 12'd3; end
            S_L_OUT:   rec_valid = 1'b1;
            S_E_OUT: begin
                rec_valid = 1'b1;
                rec_ext   = 1'b1;
                rec_id    = xf.id;
                rec_ver   = xf.ver;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgw_walker_chk.sv
module cfgw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        rec_valid,
    input logic        rec_ready,
    input logic        rec_ext,
    input logic [15:0] rec_id,
    input logic [11:0] rec_offset,
    input logic [3:0]  rec_ver,
    input logic        busy,
    input logic        done
);
    // R11: an offered record holds while it waits
    p_rec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_id) && $stable(rec_offset)
                                    && $stable(rec_ext) && $stable(rec_ver));

    // R11: no read runs while a record is offered
    p_no_read_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !rd_en);

    // R2 / R10: legacy records lie in the legacy region, aligned, version 0
    p_leg_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ext |-> rec_offset >= 12'h040 && rec_offset <= 12'h0FF
                                  && rec_offset[1:0] == 2'b00 && rec_ver == 4'h0
                                  && rec_id[15:8] == 8'h00);

    // R10: extended records lie at or above 0x100
    p_ext_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ext |-> rec_offset >= 12'h100);

    // R12: done and busy never together; finished block is quiet
    p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !rd_en && !rec_valid);
endmodule

bind cfg_cap_walker cfgw_walker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_ext(rec_ext), .rec_id(rec_id),
    .rec_offset(rec_offset), .rec_ver(rec_ver), .busy(busy), .done(done));

// File: tb/cfg_cap_walker_bench.sv
`timescale 1ns/1ps
module cfg_cap_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        space_4k = 1'b0;
    logic        rd_en;
    logic [11:0] rd_addr;
    logic [7:0]  rd_data;
    logic        rec_valid;
    logic        rec_ready = 1'b1;
    logic        rec_ext;
    logic [15:0] rec_id;
    logic [11:0] rec_offset;
    logic [3:0]  rec_ver;
    logic        busy, done, is_pcie, has_aer, has_rebar, err;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    logic [7:0] mem [4096];

    logic        log_clr = 1'b0;
    int          n_rec;
    logic [15:0] l_id  [16];
    logic [11:0] l_off [16];
    logic        l_ext [16];
    logic [3:0]  l_ver [16];

    always #2 clk = ~clk;

    cfg_cap_walker u_cfg_cap_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .space_4k(space_4k),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_ext(rec_ext),
        .rec_id(rec_id), .rec_offset(rec_offset), .rec_ver(rec_ver),
        .busy(busy), .done(done), .is_pcie(is_pcie), .has_aer(has_aer),
        .has_rebar(has_rebar), .err(err));

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    always @(posedge clk) begin
        if (log_clr) n_rec <= 0;
        else if (rec_valid && rec_ready) begin
            if (n_rec < 16) begin
                l_id[n_rec]  <= rec_id;
                l_off[n_rec] <= rec_offset;
                l_ext[n_rec] <= rec_ext;
                l_ver[n_rec] <= rec_ver;
            end
            n_rec <= n_rec + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wipe();
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    endtask

    task automatic xhdr(input int a, input logic [15:0] id, input logic [3:0] ver,
                        input logic [11:0] nxt);
        mem[a]   = id[7:0];
        mem[a+1] = id[15:8];
        mem[a+2] = {nxt[3:0], ver};
        mem[a+3] = nxt[11:4];
    endtask

    task automatic launch(input logic sz);
        @(negedge clk);
        log_clr = 1'b1;
        space_4k = sz;
        @(negedge clk);
        log_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check({tag, " done reached"}, {31'h0, done}, 32'h1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R12 reset done", {31'h0, done}, 32'h0);
        check("R12 reset busy", {31'h0, busy}, 32'h0);
        check("R12 reset rec_valid", {31'h0, rec_valid}, 32'h0);
        check("R12 reset err", {31'h0, err}, 32'h0);
    endtask

    task automatic t_nocap();
        wipe();
        mem[6] = 8'hEF;
        mem[12'h34] = 8'h40;
        mem[12'h40] = 8'h10;
        launch(1'b1);
        wait_done("R1");
        check("R1 no records", n_rec, 0);
        check("R1 err low", {31'h0, err}, 32'h0);
        check("R1 not pcie", {31'h0, is_pcie}, 32'h0);
    endtask

    task automatic t_legacy();
        wipe();
        mem[6] = 8'h10;
        mem[12'h34] = 8'h43;
        mem[12'h40] = 8'h01; mem[12'h41] = 8'h50;
        mem[12'h50] = 8'h05; mem[12'h51] = 8'h7B;
        mem[12'h78] = 8'h10; mem[12'h79] = 8'h00;
        xhdr(12'h100, 16'h0001, 4'h1, 12'h000);
        launch(1'b0);
        wait_done("R2");
        check("R3 record count, no extended", n_rec, 3);
        check("R2 rec0 id", l_id[0], 32'h01);
        check("R2 rec0 off", l_off[0], 32'h40);
        check("R2 rec1 id", l_id[1], 32'h05);
        check("R2 rec1 off", l_off[1], 32'h50);
        check("R2 rec2 off masked", l_off[2], 32'h78);
        check("R2 rec2 ext flag", {31'h0, l_ext[2]}, 32'h0);
        check("R4 is_pcie set", {31'h0, is_pcie}, 32'h1);
        check("R3 no aer", {31'h0, has_aer}, 32'h0);
        check("R3 err low", {31'h0, err}, 32'h0);
    endtask

    task automatic t_ext_empty();
        wipe();
        mem[6] = 8'h10;
        mem[12'h34] = 8'h60;
        mem[12'h60] = 8'h05; mem[12'h61] = 8'h00;
        launch(1'b1);
        wait_done("R7");
        check("R7 empty extended list", n_rec, 1);
        check("R4 no pcie id", {31'h0, is_pcie}, 32'h0);
        check("R7 err low", {31'h0, err}, 32'h0);
    endtask

    task automatic setup_ext();
        wipe();
        mem[6] = 8'h10;
        mem[12'h34] = 8'h60;
        mem[12'h60] = 8'h10; mem[12'h61] = 8'h00;
        xhdr(12'h100, 16'h0001, 4'h2, 12'h148);
        xhdr(12'h148, 16'h0015, 4'h1, 12'h2A4);
        xhdr(12'h2A4, 16'hABCD, 4'h3, 12'h000);
    endtask

    task automatic check_ext_result();
        check("R6 record count", n_rec, 4);
        check("R5 rec1 ext", {31'h0, l_ext[1]}, 32'h1);
        check("R5 rec1 id", l_id[1], 32'h0001);
        check("R5 rec1 off", l_off[1], 32'h100);
        check("R5 rec1 ver", l_ver[1], 32'h2);
        check("R5 rec2 off", l_off[2], 32'h148);
        check("R5 rec2 ver", l_ver[2], 32'h1);
        check("R6 last id", l_id[3], 32'hABCD);
        check("R6 last off", l_off[3], 32'h2A4);
        check("R8 aer", {31'h0, has_aer}, 32'h1);
        check("R8 rebar", {31'h0, has_rebar}, 32'h1);
        check("R5 pcie", {31'h0, is_pcie}, 32'h1);
        check("R6 err low", {31'h0, err}, 32'h0);
    endtask

    task automatic t_ext();
        setup_ext();
        launch(1'b1);
        wait_done("R5");
        check_ext_result();
    endtask

    task automatic t_stall();
        logic ok;
        logic [15:0] held_id;
        logic [11:0] held_off;
        setup_ext();
        rec_ready = 1'b0;
        launch(1'b1);
        for (int r = 0; r < 2; r++) begin
            int t = 0;
            while (!rec_valid && t < 200) begin @(negedge clk); t++; end
            held_id = rec_id;
            held_off = rec_offset;
            ok = rec_valid;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (!rec_valid || rec_id !== held_id || rec_offset !== held_off || rd_en)
                    ok = 1'b0;
            end
            check("R11 record held, no reads while stalled", {31'h0, ok}, 32'h1);
            rec_ready = 1'b1;
            @(negedge clk);
            rec_ready = 1'b0;
        end
        rec_ready = 1'b1;
        wait_done("R11");
        check_ext_result();
    endtask

    task automatic t_hop_leg();
        wipe();
        mem[6] = 8'h10;
        mem[12'h34] = 8'h40;
        mem[12'h40] = 8'h09; mem[12'h41] = 8'h40;
        launch(1'b1);
        wait_done("R9 legacy");
        check("R9 legacy hop count", n_rec, 48);
        check("R9 legacy err", {31'h0, err}, 32'h1);
    endtask

    task automatic t_hop_ext();
        wipe();
        mem[6] = 8'h10;
        xhdr(12'h100, 16'h000B, 4'h1, 12'h100);
        launch(1'b1);
        wait_done("R9 extended");
        check("R9 extended hop count", n_rec, 960);
        check("R9 extended err", {31'h0, err}, 32'h1);
    endtask

    task automatic t_range();
        wipe();
        mem[6] = 8'h10;
        mem[12'h34] = 8'h20;
        launch(1'b1);
        wait_done("R10 legacy");
        check("R10 legacy low pointer no record", n_rec, 0);
        check("R10 legacy low pointer err", {31'h0, err}, 32'h1);

        wipe();
        mem[6] = 8'h10;
        xhdr(12'h100, 16'h0015, 4'h1, 12'h0F0);
        launch(1'b1);
        wait_done("R10 extended");
        check("R10 extended low pointer records", n_rec, 1);
        check("R10 extended low pointer err", {31'h0, err}, 32'h1);
    endtask

    task automatic t_restart();
        wipe();
        mem[6] = 8'h00;
        launch(1'b1);
        wait_done("R12 restart");
        check("R12 err cleared", {31'h0, err}, 32'h0);
        check("R12 rebar cleared", {31'h0, has_rebar}, 32'h0);
        check("R12 restart records", n_rec, 0);
    endtask

    initial begin
        wipe();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_nocap();
        t_legacy();
        t_ext_empty();
        t_ext();
        t_stall();
        t_hop_leg();
        t_hop_ext();
        t_range();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule